// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block sits next to a UART transmitter and receiver and handles in-band flow control. On the receive side it inspects every received byte. Bytes that match the configured Xon or Xoff characters are removed from the data stream, and they stop or release the local transmitter. All other bytes are passed on to the receive FIFO. On the transmit side it turns receive-FIFO level events into requests that insert Xon or Xoff characters into the outgoing stream. Each direction can work with single characters or with two-byte sequences.

A special-character mode replaces flow-control recognition. In this mode every received byte is compared with the second Xoff character register. A matching byte is still stored, and a sticky flag is raised that a status read clears. The 4-bit mode field is split in two. Bits [3:2] select the transmit behaviour and bits [1:0] select the receive behaviour. In both fields 00 is off, 10 selects the first character set (Xon1/Xoff1), 01 selects the second set (Xon2/Xoff2), and 11 selects two-byte sequences with the "1" byte first. The mode field is expected to stay stable while traffic flows, and received-byte strobes never arrive on two consecutive cycles.

Top module: `swfc_top`

## Requirements
- R1: After reset, tx_halt_o, ins_req_o, fifo_wr_o and spec_flag_o are all 0.
- R2: With receive mode 10 (or 01), a byte equal to Xoff1 (Xoff2) sets tx_halt_o and a byte equal to Xon1 (Xon2) clears it. The matched byte is not written to the FIFO. Bytes from the other character set are not recognised.
- R3: A byte that is not consumed as flow control is written to the FIFO unchanged, with fifo_wr_o high for one cycle, on the clock edge that follows its strobe. With receive mode 00 every byte is forwarded.
- R4: With receive mode 11, Xoff1 followed by Xoff2 sets tx_halt_o, and Xon1 followed by Xon2 clears it. None of the four bytes reaches the FIFO.
- R5: In receive mode 11, when a held first byte is followed by a wrong second byte, the held byte is written on the next edge. If the new byte equals Xon1 or Xoff1, the new byte becomes the held first byte. Otherwise the new byte is written one cycle after the held byte.
- R6: A received Xoff does not raise tx_halt_o while tx_busy_i is 1. tx_halt_o rises on the first edge at which tx_busy_i is 0, unless an Xon arrives first.
- R7: With spec_en_i = 1, every received byte is compared with Xoff2, with bit 0 of the register matched against the byte's LSB. A match sets spec_flag_o. Every byte is forwarded to the FIFO, and no Xon/Xoff is acted on, whatever the mode bits hold.
- R8: spec_flag_o stays set until a cycle with stat_rd_i = 1 clears it. A new match in that same cycle keeps it set.
- R9: Transmit mode 10 inserts Xon1/Xoff1 and transmit mode 01 inserts Xon2/Xoff2. Transmit mode 11 inserts the "1" byte and then, after its acknowledge, the "2" byte. rxq_hi_i requests Xoff (ins_xoff_o = 1), rxq_lo_i requests Xon, and mode 00 produces no request.
- R10: ins_req_o stays high until ins_ack_i. If rxq_hi_i and rxq_lo_i arrive together, Xoff is chosen. A new event replaces a request whose first byte has not yet been acknowledged.
- R11: tx_halt_o is cleared on the edge after receive recognition becomes inactive (receive mode 00 or spec_en_i = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_mode_i | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| xon1_i | input | 8 | First Xon character |
| xon2_i | input | 8 | Second Xon character |
| xoff1_i | input | 8 | First Xoff character |
| xoff2_i | input | 8 | Second Xoff character; also the special-character pattern |
| spec_en_i | input | 1 | Special-character detect enable |
| rx_vld_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rxq_hi_i | input | 1 | Receive FIFO reached its upper level (pulse) |
| rxq_lo_i | input | 1 | Receive FIFO drained below its lower level (pulse) |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| ins_ack_i | input | 1 | Transmitter accepted the offered insert byte |
| stat_rd_i | input | 1 | Status read; clears the special flag |
| tx_halt_o | output | 1 | Hold off the transmitter |
| ins_req_o | output | 1 | Request to insert a flow-control byte |
| ins_xoff_o | output | 1 | 1 when the requested byte is an Xoff |
| ins_byte_o | output | 8 | Byte to insert |
| fifo_wr_o | output | 1 | Write strobe toward the receive FIFO |
| fifo_dat_o | output | 8 | Byte toward the receive FIFO |
| spec_flag_o | output | 1 | Sticky special-character flag |

## Verification
The assertions check the following on every cycle:
- a recognised single character never produces a FIFO write;
- an Xon always leaves the halt low;
- the halt never rises while the transmitter is busy, or while recognition is inactive;
- the special flag holds until a read and is set by every match;
- a pending insert request never drops without an acknowledge.

Other behaviour is visible only in the bench scenarios:
- the exact bytes and the order in which they reach the FIFO after a broken two-byte sequence, including the re-arm case;
- which character each transmit mode offers;
- the Xoff priority and the replacement of unsent requests;
- the bit-order check of the special-character comparison.

// File: rtl/swfc_pkg.sv
// Shared types for the software flow control engine.
// Assumes: mode fields are two bits wide, encoded identically for transmit and receive.
package swfc_pkg;

    // Selection of character set for one direction
    typedef enum logic [1:0] {
        FC_OFF  = 2'b00,
        FC_SET2 = 2'b01,
        FC_SET1 = 2'b10,
        FC_PAIR = 2'b11
    } fc_sel_e;

    // Two-byte receive matcher state
    typedef enum logic [1:0] {
        PM_IDLE = 2'b00,
        PM_ON1  = 2'b01,
        PM_OFF1 = 2'b10
    } pair_st_e;

endpackage

// File: rtl/swfc_rx_match.sv
// Receive-side recognition of Xon/Xoff characters and the FIFO write path.
// What it does: removes recognised flow-control bytes from the stream, emits
// one-cycle xon/xoff events, and forwards every other byte one edge later.
// A broken two-byte sequence releases the held byte, then replays the new one.
// Assumes: rx_vld never high on two consecutive cycles; mode stable during traffic.
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_e       rx_sel,
    input  logic          spec_en,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_byte,
    output logic          rx_active,
    output logic          xon_evt,
    output logic          xoff_evt,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_dat
);

    fc_sel_e       sel_eff;
    pair_st_e      st, st_nxt;
    logic [DW-1:0] held;
    logic [DW-1:0] rep_dat;
    logic          rep_vld;
    logic          fwd_now, flush, replay;
    logic [DW-1:0] second;

    // Special detect overrides any flow-control recognition
    always_comb sel_eff = spec_en ? FC_OFF : rx_sel;
    assign rx_active = (sel_eff != FC_OFF);

    // Second byte expected in the current pair state
    always_comb second = (st == PM_ON1) ? xon2 : xoff2;

    // Classify the incoming byte and choose the next matcher state
    always_comb begin
        xon_evt  = 1'b0;
        xoff_evt = 1'b0;
        fwd_now  = 1'b0;
        flush    = 1'b0;
        replay   = 1'b0;
        st_nxt   = (sel_eff == FC_PAIR) ? st : PM_IDLE;
        if (rx_vld) begin
            unique case (sel_eff)
                FC_OFF: fwd_now = 1'b1;
                FC_SET1: begin
                    if (rx_byte == xon1)       xon_evt  = 1'b1;
                    else if (rx_byte == xoff1) xoff_evt = 1'b1;
                    else                       fwd_now  = 1'b1;
                end
                FC_SET2: begin
                    if (rx_byte == xon2)       xon_evt  = 1'b1;
                    else if (rx_byte == xoff2) xoff_evt = 1'b1;
                    else                       fwd_now  = 1'b1;
                end
                FC_PAIR: begin
                    if (st == PM_IDLE) begin
                        if (rx_byte == xon1)       st_nxt  = PM_ON1;
                        else if (rx_byte == xoff1) st_nxt  = PM_OFF1;
                        else                       fwd_now = 1'b1;
                    end else if (rx_byte == second) begin
                        xon_evt  = (st == PM_ON1);
                        xoff_evt = (st == PM_OFF1);
                        st_nxt   = PM_IDLE;
                    end else begin
                        flush = 1'b1;
                        if (rx_byte == xon1)       st_nxt = PM_ON1;
                        else if (rx_byte == xoff1) st_nxt = PM_OFF1;
                        else begin
                            st_nxt = PM_IDLE;
                            replay = 1'b1;
                        end
                    end
                end
                default: fwd_now = 1'b1;
            endcase
        end
    end

    // Matcher state and held first byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= PM_IDLE;
            held <= '0;
        end else begin
            st <= st_nxt;
            if (rx_vld && st_nxt != PM_IDLE) held <= rx_byte;
        end
    end

    // FIFO write path: flush of held byte, direct forward, or replay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr  <= 1'b0;
            fifo_dat <= '0;
            rep_vld  <= 1'b0;
            rep_dat  <= '0;
        end else begin
            rep_vld <= replay;
            if (replay) rep_dat <= rx_byte;
            if (flush) begin
                fifo_wr  <= 1'b1;
                fifo_dat <= held;
            end else if (fwd_now) begin
                fifo_wr  <= 1'b1;
                fifo_dat <= rx_byte;
            end else if (rep_vld) begin
                fifo_wr  <= 1'b1;
                fifo_dat <= rep_dat;
            end else begin
                fifo_wr  <= 1'b0;
            end
        end
    end

    AST_RX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> !rx_vld); // R5
    AST_SINGLE_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && sel_eff == FC_SET1 && (rx_byte == xon1 || rx_byte == xoff1)) |=> !fifo_wr); // R2
    AST_PAIR_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && sel_eff == FC_PAIR && st != PM_IDLE && rx_byte != second
         && rx_byte != xon1 && rx_byte != xoff1) |=> fifo_wr ##1 fifo_wr); // R5
    AST_SPEC_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_en && rx_vld) |=> (fifo_wr && fifo_dat == $past(rx_byte))); // R7

endmodule

// File: rtl/swfc_halt.sv
// Transmit halt control.
// What it does: turns Xoff events into a halt that takes effect only once the
// transmitter is idle (between characters), and releases it on Xon.
// Assumes: xon_evt and xoff_evt are never high together.
module swfc_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_active,
    input  logic xon_evt,
    input  logic xoff_evt,
    input  logic tx_busy,
    output logic tx_halt
);

    logic pend;

    // Halt and deferred-halt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            tx_halt <= 1'b0;
        end else if (!rx_active || xon_evt) begin
            pend    <= 1'b0;
            tx_halt <= 1'b0;
        end else if (xoff_evt) begin
            if (tx_busy) pend    <= 1'b1;
            else         tx_halt <= 1'b1;
        end else if (pend && !tx_busy) begin
            pend    <= 1'b0;
            tx_halt <= 1'b1;
        end
    end

    AST_XON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        xon_evt |=> !tx_halt); // R2
    AST_HALT_WAITS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_halt) |=> !tx_halt); // R6
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> $past(xoff_evt || pend)); // R6
    AST_HALT_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> !tx_halt); // R11

endmodule

// File: rtl/swfc_tx_ins.sv
// Transmit-side insertion of Xon/Xoff characters.
// What it does: converts receive-FIFO level events into a request that offers
// one flow-control byte (or two in pair mode) to the transmitter.
// Assumes: the transmitter latches ins_byte in the cycle it raises ins_ack.
module swfc_tx_ins
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_e       tx_sel,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          lvl_hi,
    input  logic          lvl_lo,
    input  logic          ins_ack,
    output logic          ins_req,
    output logic          ins_xoff,
    output logic [DW-1:0] ins_byte
);

    logic act, kind, idx, pend_act, pend_kind;
    logic evt, ev_kind;

    // A level event only counts while transmit flow control is on; Xoff wins
    assign evt     = (lvl_hi || lvl_lo) && (tx_sel != FC_OFF);
    assign ev_kind = lvl_hi;

    // Request, byte index and queued follow-up request
    always_ff @(posedge clk) begin
        if (!rst_n || tx_sel == FC_OFF) begin
            act       <= 1'b0;
            kind      <= 1'b0;
            idx       <= 1'b0;
            pend_act  <= 1'b0;
            pend_kind <= 1'b0;
        end else if (act && ins_ack) begin
            if (tx_sel == FC_PAIR && !idx) begin
                idx <= 1'b1;
                if (evt) begin
                    pend_act  <= 1'b1;
                    pend_kind <= ev_kind;
                end
            end else begin
                idx <= 1'b0;
                if (evt) begin
                    act      <= 1'b1;
                    kind     <= ev_kind;
                    pend_act <= 1'b0;
                end else if (pend_act) begin
                    act      <= 1'b1;
                    kind     <= pend_kind;
                    pend_act <= 1'b0;
                end else begin
                    act <= 1'b0;
                end
            end
        end else if (evt) begin
            if (!act || !idx) begin
                act  <= 1'b1;
                kind <= ev_kind;
            end else begin
                pend_act  <= 1'b1;
                pend_kind <= ev_kind;
            end
        end
    end

    // Byte offered for the current mode, kind and position
    always_comb begin
        unique case (tx_sel)
            FC_SET1: ins_byte = kind ? xoff1 : xon1;
            FC_SET2: ins_byte = kind ? xoff2 : xon2;
            FC_PAIR: ins_byte = kind ? (idx ? xoff2 : xoff1) : (idx ? xon2 : xon1);
            default: ins_byte = '0;
        endcase
    end

    assign ins_req  = act;
    assign ins_xoff = kind;

    AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack && tx_sel != FC_OFF) |=> ins_req); // R10
    AST_INS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel == FC_OFF) |=> !ins_req); // R9
    AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && ins_ack && tx_sel == FC_PAIR && !idx) |=> ins_req); // R9

endmodule

// File: rtl/swfc_spec.sv
// Special-character detector.
// What it does: compares each received byte with the pattern register and
// raises a sticky flag on a match; a status read clears it.
// Assumes: the byte itself is forwarded by the receive path, not here.
module swfc_spec #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spec_en,
    input  logic [DW-1:0] pattern,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_byte,
    input  logic          stat_rd,
    output logic          spec_flag
);

    logic hit;

    // Full-width equality; bit 0 of the pattern lines up with the LSB received
    assign hit = spec_en && rx_vld && (rx_byte == pattern);

    // Sticky flag; a new match has priority over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)       spec_flag <= 1'b0;
        else if (hit)     spec_flag <= 1'b1;
        else if (stat_rd) spec_flag <= 1'b0;
    end

    AST_SPEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_en && rx_vld && rx_byte == pattern) |=> spec_flag); // R7
    AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_flag && !stat_rd) |=> spec_flag); // R8
    AST_SPEC_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_flag && !(spec_en && rx_vld)) |=> !spec_flag); // R8

endmodule

// File: rtl/swfc_top.sv
// Software flow control engine top.
// What it does: wires receive recognition, halt control, transmit insertion
// and special-character detection around a shared set of character registers.
// Assumes: fc_mode_i[3:2] is the transmit field, fc_mode_i[1:0] the receive field.
module swfc_top
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    fc_mode_i,
    input  logic [DW-1:0] xon1_i,
    input  logic [DW-1:0] xon2_i,
    input  logic [DW-1:0] xoff1_i,
    input  logic [DW-1:0] xoff2_i,
    input  logic          spec_en_i,
    input  logic          rx_vld_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          rxq_hi_i,
    input  logic          rxq_lo_i,
    input  logic          tx_busy_i,
    input  logic          ins_ack_i,
    input  logic          stat_rd_i,
    output logic          tx_halt_o,
    output logic          ins_req_o,
    output logic          ins_xoff_o,
    output logic [DW-1:0] ins_byte_o,
    output logic          fifo_wr_o,
    output logic [DW-1:0] fifo_dat_o,
    output logic          spec_flag_o
);

    fc_sel_e rx_sel, tx_sel;
    logic    rx_active, xon_evt, xoff_evt;

    // Split the mode field into the two direction selects
    assign rx_sel = fc_sel_e'(fc_mode_i[1:0]);
    assign tx_sel = fc_sel_e'(fc_mode_i[3:2]);

    swfc_rx_match #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .spec_en(spec_en_i),
        .xon1(xon1_i), .xon2(xon2_i), .xoff1(xoff1_i), .xoff2(xoff2_i),
        .rx_vld(rx_vld_i), .rx_byte(rx_byte_i), .rx_active(rx_active),
        .xon_evt(xon_evt), .xoff_evt(xoff_evt),
        .fifo_wr(fifo_wr_o), .fifo_dat(fifo_dat_o)
    );

    swfc_halt u_halt (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active),
        .xon_evt(xon_evt), .xoff_evt(xoff_evt),
        .tx_busy(tx_busy_i), .tx_halt(tx_halt_o)
    );

    swfc_tx_ins #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
        .xon1(xon1_i), .xon2(xon2_i), .xoff1(xoff1_i), .xoff2(xoff2_i),
        .lvl_hi(rxq_hi_i), .lvl_lo(rxq_lo_i), .ins_ack(ins_ack_i),
        .ins_req(ins_req_o), .ins_xoff(ins_xoff_o), .ins_byte(ins_byte_o)
    );

    swfc_spec #(.DW(DW)) u_spec (
        .clk(clk), .rst_n(rst_n), .spec_en(spec_en_i), .pattern(xoff2_i),
        .rx_vld(rx_vld_i), .rx_byte(rx_byte_i), .stat_rd(stat_rd_i),
        .spec_flag(spec_flag_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tx_halt_o && !ins_req_o && !fifo_wr_o && !spec_flag_o)); // R1

endmodule

// File: tb/sim_swfc_top.sv
`timescale 1ns/1ps
module sim_swfc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fc_mode = 4'b0000;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h21, xoff1 = 8'h13, xoff2 = 8'h23;
    logic       spec_en = 1'b0, rx_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rxq_hi = 1'b0, rxq_lo = 1'b0, tx_busy = 1'b0, ins_ack = 1'b0, stat_rd = 1'b0;
    logic       tx_halt, ins_req, ins_xoff, fifo_wr, spec_flag;
    logic [7:0] ins_byte, fifo_dat;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    swfc_top u0 (
        .clk(clk), .rst_n(rst_n), .fc_mode_i(fc_mode),
        .xon1_i(xon1), .xon2_i(xon2), .xoff1_i(xoff1), .xoff2_i(xoff2),
        .spec_en_i(spec_en), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
        .rxq_hi_i(rxq_hi), .rxq_lo_i(rxq_lo), .tx_busy_i(tx_busy),
        .ins_ack_i(ins_ack), .stat_rd_i(stat_rd),
        .tx_halt_o(tx_halt), .ins_req_o(ins_req), .ins_xoff_o(ins_xoff),
        .ins_byte_o(ins_byte), .fifo_wr_o(fifo_wr), .fifo_dat_o(fifo_dat),
        .spec_flag_o(spec_flag)
    );

    // Vector: {mode[22:19], spec[18], byte[17:10], exp_wr[9], exp_dat[8:1], exp_halt[0]}
    localparam logic [22:0] VEC [9] = '{
        {4'b0000, 1'b0, 8'h13, 1'b1, 8'h13, 1'b0},  // R3 mode off forwards
        {4'b0010, 1'b0, 8'h13, 1'b0, 8'h00, 1'b1},  // R2 Xoff1 halts
        {4'b0010, 1'b0, 8'h55, 1'b1, 8'h55, 1'b1},  // R3 plain byte passes
        {4'b0010, 1'b0, 8'h11, 1'b0, 8'h00, 1'b0},  // R2 Xon1 releases
        {4'b0001, 1'b0, 8'h13, 1'b1, 8'h13, 1'b0},  // R2 set1 char ignored in set2
        {4'b0001, 1'b0, 8'h23, 1'b0, 8'h00, 1'b1},  // R2 Xoff2 halts
        {4'b0001, 1'b0, 8'h21, 1'b0, 8'h00, 1'b0},  // R2 Xon2 releases
        {4'b0000, 1'b1, 8'h23, 1'b1, 8'h23, 1'b0},  // R7 match still stored
        {4'b0001, 1'b1, 8'h23, 1'b1, 8'h23, 1'b0}   // R7 no Xoff action
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One idle cycle, then a one-cycle strobe; returns at the negedge after it
    task automatic send(input logic [7:0] b);
        step();
        rx_vld  = 1'b1;
        rx_byte = b;
        step();
        rx_vld  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 halt", tx_halt, 0);
        chk("R1 req", ins_req, 0);
        chk("R1 wr", fifo_wr, 0);
        chk("R1 flag", spec_flag, 0);
        rst_n = 1'b1;

        // Table walk: single-character receive modes and special detect
        for (int i = 0; i < 9; i++) begin
            fc_mode = VEC[i][22:19];
            spec_en = VEC[i][18];
            send(VEC[i][17:10]);
            chk(VEC[i][18] ? "R7 wr" : "R3 wr", fifo_wr, VEC[i][9]);
            if (VEC[i][9]) chk(VEC[i][18] ? "R7 dat" : "R3 dat", fifo_dat, VEC[i][8:1]);
            chk(VEC[i][18] ? "R7 halt" : "R2 halt", tx_halt, VEC[i][0]);
        end

        // R8 flag held, then cleared by a read
        step();
        chk("R8 flag held", spec_flag, 1);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        chk("R8 flag cleared", spec_flag, 0);

        // R7 bit order: pattern 01 must not match 80
        xoff2 = 8'h01;
        send(8'h80);
        chk("R7 bit order", spec_flag, 0);
        send(8'h01);
        chk("R7 lsb match", spec_flag, 1);
        // R8 match with read in same cycle keeps flag
        step();
        stat_rd = 1'b1; rx_vld = 1'b1; rx_byte = 8'h01;
        step();
        stat_rd = 1'b0; rx_vld = 1'b0;
        chk("R8 set wins", spec_flag, 1);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        xoff2 = 8'h23;
        spec_en = 1'b0;

        // R4 two-byte sequences
        fc_mode = 4'b0011;
        send(8'h13);
        chk("R4 first held", fifo_wr, 0);
        send(8'h23);
        chk("R4 second swallowed", fifo_wr, 0);
        chk("R4 halt", tx_halt, 1);
        send(8'h11);
        send(8'h21);
        chk("R4 xon wr", fifo_wr, 0);
        chk("R4 release", tx_halt, 0);

        // R5 mismatch: held then replay
        send(8'h11);
        send(8'h55);
        chk("R5 flush wr", fifo_wr, 1);
        chk("R5 flush dat", fifo_dat, 8'h11);
        step();
        chk("R5 replay wr", fifo_wr, 1);
        chk("R5 replay dat", fifo_dat, 8'h55);
        // R5 re-arm
        send(8'h11);
        send(8'h11);
        chk("R5 rearm dat", fifo_dat, 8'h11);
        step();
        chk("R5 no replay", fifo_wr, 0);
        send(8'h21);
        chk("R5 rearm completes", fifo_wr, 0);

        // R6 halt deferred while busy
        fc_mode = 4'b0010;
        tx_busy = 1'b1;
        send(8'h13);
        chk("R6 no halt busy", tx_halt, 0);
        step();
        chk("R6 still waiting", tx_halt, 0);
        tx_busy = 1'b0;
        step();
        chk("R6 halt after idle", tx_halt, 1);
        // R11 disable clears halt
        fc_mode = 4'b0000;
        step();
        chk("R11 cleared", tx_halt, 0);

        // R9 transmit insertion
        fc_mode = 4'b1000;
        rxq_hi = 1'b1;
        step();
        rxq_hi = 1'b0;
        chk("R9 req", ins_req, 1);
        chk("R9 xoff1 byte", ins_byte, 8'h13);
        chk("R9 xoff flag", ins_xoff, 1);
        step();
        chk("R10 held", ins_req, 1);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R10 ack clears", ins_req, 0);

        fc_mode = 4'b0100;
        rxq_lo = 1'b1;
        step();
        rxq_lo = 1'b0;
        chk("R9 xon2 byte", ins_byte, 8'h21);
        chk("R9 xon flag", ins_xoff, 0);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;

        fc_mode = 4'b1100;
        rxq_hi = 1'b1;
        step();
        rxq_hi = 1'b0;
        chk("R9 pair first", ins_byte, 8'h13);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R9 pair req", ins_req, 1);
        chk("R9 pair second", ins_byte, 8'h23);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R9 pair done", ins_req, 0);

        fc_mode = 4'b0000;
        rxq_hi = 1'b1;
        step();
        rxq_hi = 1'b0;
        chk("R9 off no req", ins_req, 0);

        // R10 priority and replacement
        fc_mode = 4'b1000;
        rxq_hi = 1'b1; rxq_lo = 1'b1;
        step();
        rxq_hi = 1'b0; rxq_lo = 1'b0;
        chk("R10 xoff priority", ins_byte, 8'h13);
        rxq_lo = 1'b1;
        step();
        rxq_lo = 1'b0;
        chk("R10 replaced", ins_byte, 8'h11);
        ins_ack = 1'b1;
        step();
        ins_ack = 1'b0;
        chk("R10 final clear", ins_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule